// File: doc/BRIEF.md
# Register-Controlled Shifter with Carry

This block shifts a 32-bit operand by an amount held in a register and returns both the shifted value and the updated carry flag. It supports four shift kinds: logical left, logical right, arithmetic right and rotate right. It sits in the execute stage of a datapath. The operand, the amount word, the shift kind and the incoming carry arrive together, and the result and carry are valid in the same cycle. The block is purely combinational.

The amount word is a full register. Only its low byte sets how far to shift, so the amount ranges from 0 to 255. Amounts of zero, exactly the operand width, and above the operand width each follow their own carry rule. Rotation folds the amount modulo the width. A rotate amount that is a non-zero multiple of the width still changes the carry.

Top module: `shift_carry_unit`

## Requirements
- R1: Only bits [7:0] of `amt_word_i` set the shift amount. Bits [31:8] have no effect on `result_o` or `carry_o`.
- R2: When the amount is zero, `result_o` equals `opnd_i` and `carry_o` equals `carry_i`, whatever the mode.
- R3: For a logical left shift (mode 0) by n, with n from 1 to 31, `result_o` is `opnd_i << n` with zeros shifted in, and `carry_o` is `opnd_i[32-n]`.
- R4: For a logical left shift by exactly 32, the result is 0 and the carry is `opnd_i[0]`. For a logical left shift by more than 32, the result is 0 and the carry is 0.
- R5: For a logical right shift (mode 1) by n, with n from 1 to 31, the result is `opnd_i >> n` with zeros shifted in, and the carry is `opnd_i[n-1]`.
- R6: For a logical right shift by exactly 32, the result is 0 and the carry is `opnd_i[31]`. For a logical right shift by more than 32, the result is 0 and the carry is 0.
- R7: For an arithmetic right shift (mode 2) by n, with n from 1 to 31, the result is `opnd_i` shifted right with copies of bit 31 shifted in, and the carry is `opnd_i[n-1]`.
- R8: For an arithmetic right shift by 32 or more, every result bit equals `opnd_i[31]` and the carry equals `opnd_i[31]`.
- R9: For a rotate right (mode 3), let r be amount[4:0]. When r is non-zero, the result is `opnd_i` rotated right by r and the carry is `opnd_i[r-1]`.
- R10: For a rotate right where amount[4:0] is zero but the 8-bit amount is not zero, the result equals `opnd_i` and the carry is `opnd_i[31]`.
- R11: The mode encoding is 0 = logical left, 1 = logical right, 2 = arithmetic right, 3 = rotate right. The outputs follow the inputs combinationally, with no register in the path.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opnd_i | input | 32 | Operand to shift |
| amt_word_i | input | 32 | Amount register; only bits [7:0] are used |
| mode_i | input | 2 | Shift kind: 0 LSL, 1 LSR, 2 ASR, 3 ROR |
| carry_i | input | 1 | Current carry flag |
| result_o | output | 32 | Shifted operand |
| carry_o | output | 1 | Updated carry flag |

## Verification
The assertions are sampled combinationally. They assume the inputs are two-state and stable while they are evaluated. The bench meets this by changing inputs only just after a rising clock edge and comparing results at the falling edge.

The checker also assumes the operand width is a power of two, so that rotation folds cleanly. The stimulus stays within these limits and does the following:
- It sweeps every region of the low amount byte: zero, 1 to 31, exactly 32, 33 to 255, and non-zero multiples of 32.
- It puts arbitrary values in the upper amount bits.
- It drives only the four defined mode codes.

// File: rtl/shift_carry_pkg.sv
// Shared types for the register-controlled shifter.
// Assumes: the mode encoding below is fixed by the surrounding decoder.
package shift_carry_pkg;

    typedef enum logic [1:0] {
        SH_LSL = 2'd0,
        SH_LSR = 2'd1,
        SH_ASR = 2'd2,
        SH_ROR = 2'd3
    } shift_mode_e;

endpackage

// File: rtl/shift_amt_decode.sv
// Extracts the shift amount from the amount word and classifies it against
// the operand width. Produces the folded rotate amount as well.
// Assumes: WIDTH is a power of two and 2**AMT_BITS > WIDTH.
module shift_amt_decode #(
    parameter int WIDTH    = 32,
    parameter int AMT_WORD = 32,
    parameter int AMT_BITS = 8,
    localparam int IDX_BITS = $clog2(WIDTH)
) (
    input  logic [AMT_WORD-1:0] amt_word_i,
    output logic [AMT_BITS-1:0] amt_o,
    output logic                amt_zero_o,
    output logic                amt_eq_w_o,
    output logic                amt_gt_w_o,
    output logic [IDX_BITS-1:0] rot_o,
    output logic                rot_zero_o
);

    localparam logic [AMT_BITS-1:0] WIDTH_AMT = AMT_BITS'(WIDTH);

    // Classify the low amount byte against the operand width.
    always_comb begin
        amt_o      = amt_word_i[AMT_BITS-1:0];
        amt_zero_o = (amt_o == '0);
        amt_eq_w_o = (amt_o == WIDTH_AMT);
        amt_gt_w_o = (amt_o > WIDTH_AMT);
        rot_o      = amt_o[IDX_BITS-1:0];
        rot_zero_o = (rot_o == '0);
    end

endmodule

// File: rtl/shift_result_path.sv
// Forms the shifted operand for each of the four shift kinds.
// Assumes: the amount flags come from shift_amt_decode for the same amount.
module shift_result_path
    import shift_carry_pkg::*;
#(
    parameter int WIDTH    = 32,
    parameter int AMT_BITS = 8,
    localparam int IDX_BITS = $clog2(WIDTH)
) (
    input  logic [WIDTH-1:0]    opnd_i,
    input  shift_mode_e         mode_i,
    input  logic [AMT_BITS-1:0] amt_i,
    input  logic                amt_eq_w_i,
    input  logic                amt_gt_w_i,
    input  logic [IDX_BITS-1:0] rot_i,
    input  logic                rot_zero_i,
    output logic [WIDTH-1:0]    result_o
);

    localparam logic [IDX_BITS:0] WIDTH_EXT = (IDX_BITS+1)'(WIDTH);

    logic             amt_ge_w;
    logic [IDX_BITS:0] rot_back;

    // Helper terms: out-of-range amount flag and the back-rotation count.
    always_comb begin
        amt_ge_w = amt_eq_w_i | amt_gt_w_i;
        rot_back = WIDTH_EXT - {1'b0, rot_i};
    end

    // Select the shifted value for the requested mode.
    always_comb begin
        unique case (mode_i)
            SH_LSL: result_o = amt_ge_w ? '0 : (opnd_i << amt_i);
            SH_LSR: result_o = amt_ge_w ? '0 : (opnd_i >> amt_i);
            SH_ASR: result_o = amt_ge_w ? {WIDTH{opnd_i[WIDTH-1]}}
                                        : WIDTH'($signed(opnd_i) >>> amt_i);
            SH_ROR: result_o = rot_zero_i ? opnd_i
                                          : ((opnd_i >> rot_i) | (opnd_i << rot_back));
            default: result_o = opnd_i;
        endcase
    end

endmodule

// File: rtl/shift_carry_select.sv
// Picks the new carry flag: the last bit shifted out, or the incoming carry
// when nothing is shifted.
// Assumes: WIDTH is a power of two, so index arithmetic wraps modulo WIDTH.
module shift_carry_select
    import shift_carry_pkg::*;
#(
    parameter int WIDTH    = 32,
    parameter int AMT_BITS = 8,
    localparam int IDX_BITS = $clog2(WIDTH)
) (
    input  logic [WIDTH-1:0]    opnd_i,
    input  shift_mode_e         mode_i,
    input  logic                carry_i,
    input  logic [AMT_BITS-1:0] amt_i,
    input  logic                amt_zero_i,
    input  logic                amt_eq_w_i,
    input  logic                amt_gt_w_i,
    input  logic [IDX_BITS-1:0] rot_i,
    input  logic                rot_zero_i,
    output logic                carry_o
);

    logic [IDX_BITS-1:0] lo_idx;
    logic [IDX_BITS-1:0] up_idx;
    logic [IDX_BITS-1:0] rot_idx;

    // Bit positions of the last bit leaving the word, valid for in-range amounts.
    always_comb begin
        lo_idx  = amt_i[IDX_BITS-1:0] - IDX_BITS'(1);
        up_idx  = IDX_BITS'(0) - amt_i[IDX_BITS-1:0];
        rot_idx = rot_i - IDX_BITS'(1);
    end

    // Apply the per-mode carry rules, including the edge amounts.
    always_comb begin
        if (amt_zero_i) begin
            carry_o = carry_i;
        end else begin
            unique case (mode_i)
                SH_LSL: carry_o = amt_gt_w_i ? 1'b0 :
                                  amt_eq_w_i ? opnd_i[0] : opnd_i[up_idx];
                SH_LSR: carry_o = amt_gt_w_i ? 1'b0 :
                                  amt_eq_w_i ? opnd_i[WIDTH-1] : opnd_i[lo_idx];
                SH_ASR: carry_o = (amt_gt_w_i | amt_eq_w_i) ? opnd_i[WIDTH-1]
                                                            : opnd_i[lo_idx];
                SH_ROR: carry_o = rot_zero_i ? opnd_i[WIDTH-1] : opnd_i[rot_idx];
                default: carry_o = carry_i;
            endcase
        end
    end

endmodule

// File: rtl/shift_carry_unit.sv
// Top of the register-controlled shifter: decodes the amount, then forms the
// result and the carry in parallel paths.
// Assumes: purely combinational use; inputs settle within the cycle.
module shift_carry_unit
    import shift_carry_pkg::*;
#(
    parameter int WIDTH    = 32,
    parameter int AMT_WORD = 32,
    parameter int AMT_BITS = 8,
    localparam int IDX_BITS = $clog2(WIDTH)
) (
    input  logic [WIDTH-1:0]    opnd_i,
    input  logic [AMT_WORD-1:0] amt_word_i,
    input  logic [1:0]          mode_i,
    input  logic                carry_i,
    output logic [WIDTH-1:0]    result_o,
    output logic                carry_o
);

    logic [AMT_BITS-1:0] amt;
    logic                amt_zero;
    logic                amt_eq_w;
    logic                amt_gt_w;
    logic [IDX_BITS-1:0] rot;
    logic                rot_zero;
    logic [WIDTH-1:0]    shifted;
    shift_mode_e         mode;

    // Interpret the raw mode bits as a shift kind.
    always_comb mode = shift_mode_e'(mode_i);

    shift_amt_decode #(
        .WIDTH    (WIDTH),
        .AMT_WORD (AMT_WORD),
        .AMT_BITS (AMT_BITS)
    ) u_decode (
        .amt_word_i (amt_word_i),
        .amt_o      (amt),
        .amt_zero_o (amt_zero),
        .amt_eq_w_o (amt_eq_w),
        .amt_gt_w_o (amt_gt_w),
        .rot_o      (rot),
        .rot_zero_o (rot_zero)
    );

    shift_result_path #(
        .WIDTH    (WIDTH),
        .AMT_BITS (AMT_BITS)
    ) u_result (
        .opnd_i     (opnd_i),
        .mode_i     (mode),
        .amt_i      (amt),
        .amt_eq_w_i (amt_eq_w),
        .amt_gt_w_i (amt_gt_w),
        .rot_i      (rot),
        .rot_zero_i (rot_zero),
        .result_o   (shifted)
    );

    shift_carry_select #(
        .WIDTH    (WIDTH),
        .AMT_BITS (AMT_BITS)
    ) u_carry (
        .opnd_i     (opnd_i),
        .mode_i     (mode),
        .carry_i    (carry_i),
        .amt_i      (amt),
        .amt_zero_i (amt_zero),
        .amt_eq_w_i (amt_eq_w),
        .amt_gt_w_i (amt_gt_w),
        .rot_i      (rot),
        .rot_zero_i (rot_zero),
        .carry_o    (carry_o)
    );

    // A zero amount passes the operand through untouched in every mode.
    always_comb result_o = amt_zero ? opnd_i : shifted;

endmodule

// File: rtl/shift_carry_unit_chk.sv
// Property checker for shift_carry_unit, bound to every instance.
// Assumes: two-state inputs that are stable while sampled; WIDTH a power of two.
module shift_carry_unit_chk #(
    parameter int WIDTH    = 32,
    parameter int AMT_WORD = 32,
    parameter int AMT_BITS = 8
) (
    input logic [WIDTH-1:0]    opnd_i,
    input logic [AMT_WORD-1:0] amt_word_i,
    input logic [1:0]          mode_i,
    input logic                carry_i,
    input logic [WIDTH-1:0]    result_o,
    input logic                carry_o
);

    // Relate outputs to inputs for each amount region.
    always_comb begin
        int n;
        int rr;
        n  = int'(amt_word_i[AMT_BITS-1:0]);
        rr = n % WIDTH;

        // R2: zero amount keeps operand and carry
        p_zero_amt_r2: assert (n != 0 || (result_o == opnd_i && carry_o == carry_i))
            else $error("p_zero_amt_r2");
        // R3: low n result bits are zero after an in-range left shift
        p_lsl_low_r3: assert (!(mode_i == 2'd0 && n > 0 && n < WIDTH)
                              || ((result_o >> n) << n) == result_o)
            else $error("p_lsl_low_r3");
        // R4: left shift past the width clears everything
        p_lsl_over_r4: assert (!(mode_i == 2'd0 && n > WIDTH)
                               || (result_o == '0 && !carry_o))
            else $error("p_lsl_over_r4");
        // R5: high n result bits are zero after an in-range logical right shift
        p_lsr_high_r5: assert (!(mode_i == 2'd1 && n > 0 && n < WIDTH)
                               || ((result_o << n) >> n) == result_o)
            else $error("p_lsr_high_r5");
        // R6: logical right by exactly the width
        p_lsr_width_r6: assert (!(mode_i == 2'd1 && n == WIDTH)
                                || (result_o == '0 && carry_o == opnd_i[WIDTH-1]))
            else $error("p_lsr_width_r6");
        // R7: arithmetic right keeps the sign bit
        p_asr_sign_r7: assert (!(mode_i == 2'd2 && n > 0 && n < WIDTH)
                               || result_o[WIDTH-1] == opnd_i[WIDTH-1])
            else $error("p_asr_sign_r7");
        // R8: arithmetic right past the width fills with sign
        p_asr_fill_r8: assert (!(mode_i == 2'd2 && n >= WIDTH)
                               || (result_o == {WIDTH{opnd_i[WIDTH-1]}}
                                   && carry_o == opnd_i[WIDTH-1]))
            else $error("p_asr_fill_r8");
        // R9: rotate carry is the bit that wrapped into the top
        p_ror_carry_r9: assert (!(mode_i == 2'd3 && rr != 0)
                                || carry_o == result_o[WIDTH-1])
            else $error("p_ror_carry_r9");
        // R10: whole-word rotate leaves operand, carry from top bit
        p_ror_whole_r10: assert (!(mode_i == 2'd3 && n != 0 && rr == 0)
                                 || (result_o == opnd_i && carry_o == opnd_i[WIDTH-1]))
            else $error("p_ror_whole_r10");
    end

endmodule

bind shift_carry_unit shift_carry_unit_chk #(
    .WIDTH    (WIDTH),
    .AMT_WORD (AMT_WORD),
    .AMT_BITS (AMT_BITS)
) u_chk (
    .opnd_i     (opnd_i),
    .amt_word_i (amt_word_i),
    .mode_i     (mode_i),
    .carry_i    (carry_i),
    .result_o   (result_o),
    .carry_o    (carry_o)
);

// File: tb/shift_carry_unit_bench.sv
`timescale 1ns/1ps
// Bench for shift_carry_unit: behavioural reference model, compared every clock.
module shift_carry_unit_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] opnd;
    logic [31:0] amt_word;
    logic [1:0]  mode;
    logic        cin;
    logic [31:0] result;
    logic        cout;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    shift_carry_unit u_shift_carry_unit (
        .opnd_i     (opnd),
        .amt_word_i (amt_word),
        .mode_i     (mode),
        .carry_i    (cin),
        .result_o   (result),
        .carry_o    (cout)
    );

    // Reference: shifts a widened copy and reads the last bit shifted out.
    function automatic logic [32:0] model(logic [31:0] op, logic [31:0] aw,
                                          logic [1:0] m, logic c);
        int a;
        logic [63:0] t;
        logic [31:0] v;
        logic        cy;
        a = int'(aw & 32'hFF);
        if (a == 0) return {c, op};
        case (m)
            2'd0: begin
                if (a > 32) return 33'd0;
                t = {32'd0, op} << a;
                return {t[32], t[31:0]};
            end
            2'd1: begin
                if (a > 32) return 33'd0;
                t = {op, 32'd0} >> a;
                return {t[31], t[63:32]};
            end
            2'd2: begin
                if (a > 32) a = 32;
                t = 64'($signed({op, 32'd0}) >>> a);
                return {t[31], t[63:32]};
            end
            default: begin
                v  = op;
                cy = op[31];
                for (int k = 0; k < (a % 32); k++) begin
                    cy = v[0];
                    v  = {v[0], v[31:1]};
                end
                return {cy, v};
            end
        endcase
    endfunction

    // Requirement that a given vector exercises.
    function automatic string tag(logic [31:0] aw, logic [1:0] m);
        int a;
        a = int'(aw & 32'hFF);
        if (a == 0) return "R2";
        case (m)
            2'd0: return (a < 32) ? "R3" : "R4";
            2'd1: return (a < 32) ? "R5" : "R6";
            2'd2: return (a < 32) ? "R7" : "R8";
            default: return ((a % 32) != 0) ? "R9" : "R10";
        endcase
    endfunction

    task automatic compare(string req);
        logic [32:0] exp;
        exp = model(opnd, amt_word, mode, cin);
        checks++;
        if ({cout, result} !== exp) begin
            errors++;
            $display("FAIL %s: op=%h amt=%h mode=%0d cin=%0b got res=%h c=%0b exp res=%h c=%0b",
                     req, opnd, amt_word, mode, cin, result, cout, exp[31:0], exp[32]);
        end
    endtask

    // Drive one vector after a rising edge and compare at the falling edge.
    task automatic apply(logic [31:0] op, logic [31:0] aw, logic [1:0] m,
                         logic c, string req);
        @(posedge clk);
        #1;
        opnd = op; amt_word = aw; mode = m; cin = c;
        @(negedge clk);
        compare(req == "" ? tag(aw, m) : req);
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        #(20 * 200000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got timeout exp completion");
            finish_run();
        end
    end

    initial begin
        logic [31:0] pats [4];
        pats[0] = 32'h8000_0001;
        pats[1] = 32'h7FFF_FFFE;
        pats[2] = 32'hA5C3_0F96;
        pats[3] = 32'h0000_0000;
        opnd = '0; amt_word = '0; mode = '0; cin = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        compare("R2 reset");
        rst_n = 1'b1;

        // R11: every mode code on the same operand and amount
        for (int m = 0; m < 4; m++)
            apply(32'h8123_4567, 32'd4, 2'(m), 1'b0, "R11");

        // Directed edges per mode and operand pattern
        for (int p = 0; p < 4; p++) begin
            for (int m = 0; m < 4; m++) begin
                apply(pats[p], 32'd0,   2'(m), 1'b1, "R2");
                apply(pats[p], 32'd0,   2'(m), 1'b0, "R2");
                apply(pats[p], 32'd1,   2'(m), 1'b1, "");
                apply(pats[p], 32'd31,  2'(m), 1'b0, "");
                apply(pats[p], 32'd32,  2'(m), 1'b0, "");
                apply(pats[p], 32'd33,  2'(m), 1'b1, "");
                apply(pats[p], 32'd64,  2'(m), 1'b0, "");
                apply(pats[p], 32'd255, 2'(m), 1'b1, "");
                // R1: upper amount bits must not matter
                apply(pats[p], 32'hFFFF_FF00, 2'(m), 1'b1, "R1");
                apply(pats[p], 32'h1234_5620, 2'(m), 1'b0, "R1");
                apply(pats[p], 32'hDEAD_BE05, 2'(m), 1'b1, "R1");
            end
        end

        // Random sweep over the amount regions
        for (int i = 0; i < 3000; i++) begin
            logic [31:0] aw;
            aw = $urandom();
            case ($urandom_range(0, 3))
                0: aw[7:0] = 8'($urandom_range(0, 32));
                1: aw[7:0] = 8'($urandom_range(30, 34));
                2: aw[7:0] = 8'(32 * $urandom_range(0, 7));
                default: ;
            endcase
            apply($urandom(), aw, 2'($urandom_range(0, 3)), 1'($urandom()), "");
        end

        done = 1'b1;
        finish_run();
    end

endmodule